// File: doc/BRIEF.md
# Pipeline Serialization Controller

This block sits at the issue point of a core that runs several execution units at once. It decides when the core has to drain before an instruction may go on, and it raises two hold signals: one that stops instruction issue and one that stops instruction fetch. Two drain kinds exist. The execution kind waits until no instruction is in flight, no memory transaction is outstanding and every buffer is empty. The fetch kind waits only until every in-flight instruction has completed.

The decoder presents one instruction per cycle with a two-bit class and a tag. A synchronize-class instruction starts an execution drain. An instruction-synchronize-class instruction starts a fetch drain. While the serialize-mode bit or the debug-mode flag is set, every instruction starts a fetch drain. The instruction that starts a drain never issues first. It waits in a one-entry slot and issues in the same cycle that its last hold drops. While the slot is occupied, the decoder is told to wait. Because the drain waits on the execution units and the memory system, it has no fixed bound on its length.

Top module: `ser_ctrl`

## Requirements
- R1: After reset, `dec_ready` is 1, and `issue_valid`, `issue_hold` and `fetch_hold` are 0.
- R2: A decoded instruction of class 2'b00 that is accepted (`dec_valid` and `dec_ready`) while both mode inputs are 0 appears on `issue_valid`/`issue_tag` in the next cycle, with both holds at 0.
- R3: An accepted instruction of class 2'b01 (synchronize) raises `issue_hold` in the next cycle. The hold stays high, and that instruction does not issue, for as long as `inflight_cnt` is nonzero, `memq_cnt` is nonzero or `bufs_empty` is 0. This holds even when the core is already drained at the time of acceptance.
- R4: Release is registered. When `issue_hold` is high and the execution drain condition (`inflight_cnt`==0, `memq_cnt`==0, `bufs_empty`==1) is seen at a clock edge, `issue_hold` is 0 after that edge, and the held instruction issues in that same cycle if no fetch hold remains.
- R5: An accepted instruction of class 2'b10 (instruction-synchronize) raises `fetch_hold` in the next cycle. The hold is released the cycle after `inflight_cnt`==0 is seen, whatever `memq_cnt` and `bufs_empty` hold, and the instruction then issues.
- R6: While `ser_mode` is 1, an accepted instruction of any class raises `fetch_hold` in the next cycle and is held until the fetch drain completes.
- R7: While `dbg_mode` is 1, an accepted instruction of any class is fetch-serialized in the same way as under R6.
- R8: When both kinds are requested at once (class 2'b01 with a mode input set), both holds rise and each is released by its own drain condition. The instruction issues only once both holds are low.
- R9: While the slot is occupied, `dec_ready` is 0. An instruction presented on `dec_valid` at that time is ignored: it is never issued.
- R10: Class 2'b11 is treated exactly like class 2'b00.
- R11: `issue_valid` is never 1 while `issue_hold` or `fetch_hold` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dec_valid | input | 1 | A decoded instruction is presented |
| dec_class | input | 2 | Class: 00 plain, 01 synchronize, 10 instruction-synchronize, 11 plain |
| dec_tag | input | TAG_W (8) | Identifier of the presented instruction |
| ser_mode | input | 1 | Serialize-mode control bit |
| dbg_mode | input | 1 | Core is in debug mode |
| inflight_cnt | input | CNT_W (4) | Number of instructions still executing |
| memq_cnt | input | CNT_W (4) | Number of outstanding memory transactions |
| bufs_empty | input | 1 | All pipeline stages and instruction buffers are empty |
| dec_ready | output | 1 | The block can accept a decoded instruction |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tag | output | TAG_W (8) | Identifier of the issued instruction |
| issue_hold | output | 1 | Execution serialization in progress; issue stopped |
| fetch_hold | output | 1 | Fetch serialization in progress; fetch stopped |

## Verification
Most internal faults show up at the ports within one or two cycles. A pending flag that is lost releases a hold early, so the serializing instruction issues while a counter is still nonzero. A flag that gets stuck keeps a hold high after the drain inputs read zero, and the expected issue never arrives. A slot that fails to capture or to empty changes `dec_ready` and the order of tags in the issue stream, and the tag scoreboard catches that at the next issue. A drain decoder with its terms mixed up shows only when the bench varies the counters one at a time. For that reason each release is exercised with the other counters still busy.

// File: rtl/ser_pkg.sv
package ser_pkg;

  typedef enum logic [1:0] {
    INS_PLAIN = 2'b00,
    INS_SYNC  = 2'b01,
    INS_ISYNC = 2'b10,
    INS_RSVD  = 2'b11
  } ins_class_e;

  typedef struct packed {
    logic need_exec;
    logic need_fetch;
  } ser_req_t;

endpackage

// File: rtl/ser_classify.sv
module ser_classify
  import ser_pkg::*;
(
  input  logic       ins_valid,
  input  logic [1:0] ins_class,
  input  logic       ser_mode,
  input  logic       dbg_mode,
  output ser_req_t   req
);

  ins_class_e cls;

  always_comb begin
    cls = ins_class_e'(ins_class);
    req = '0;
    if (ins_valid) begin
      case (cls)
        INS_SYNC:  req.need_exec  = 1'b1;
        INS_ISYNC: req.need_fetch = 1'b1;
        default:   req.need_exec  = 1'b0;
      endcase
      if (ser_mode || dbg_mode) begin
        req.need_fetch = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ser_drain_mon.sv
module ser_drain_mon #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] inflight_cnt,
  input  logic [CNT_W-1:0] memq_cnt,
  input  logic             bufs_empty,
  output logic             exec_drained,
  output logic             fetch_drained
);

  localparam logic [CNT_W-1:0] ZERO = '0;

  logic no_inflight;
  logic no_memq;

  always_comb begin
    no_inflight   = (inflight_cnt == ZERO);
    no_memq       = (memq_cnt == ZERO);
    fetch_drained = no_inflight;
    exec_drained  = no_inflight && no_memq && bufs_empty;
  end

endmodule

// File: rtl/ser_hold_slot.sv
module ser_hold_slot #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             unload,
  input  logic [TAG_W-1:0] load_tag,
  output logic             full,
  output logic [TAG_W-1:0] tag
);

  logic full_nx;

  always_comb begin
    full_nx = full;
    if (load) begin
      full_nx = 1'b1;
    end else if (unload) begin
      full_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
    end else begin
      full <= full_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag <= '0;
    end else if (load) begin
      tag <= load_tag;
    end
  end

endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [1:0]       dec_class,
  input  logic [TAG_W-1:0] dec_tag,
  input  logic             ser_mode,
  input  logic             dbg_mode,
  input  logic [CNT_W-1:0] inflight_cnt,
  input  logic [CNT_W-1:0] memq_cnt,
  input  logic             bufs_empty,
  output logic             dec_ready,
  output logic             issue_valid,
  output logic [TAG_W-1:0] issue_tag,
  output logic             issue_hold,
  output logic             fetch_hold
);

  localparam int SYNC_MSB = RST_STAGES - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_MSB:0] rst_pipe;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_MSB-1:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[SYNC_MSB];

  // datapath between the submodules
  ser_req_t         req;
  logic             exec_drained;
  logic             fetch_drained;
  logic             slot_full;
  logic [TAG_W-1:0] slot_tag;
  logic             accept;
  logic             is_ser;
  logic             slot_load;
  logic             slot_unload;

  // state
  logic             exec_pend;
  logic             fetch_pend;
  logic             exec_pend_nx;
  logic             fetch_pend_nx;
  logic             issue_valid_nx;
  logic             issue_tag_en;
  logic [TAG_W-1:0] issue_tag_nx;

  ser_classify u_classify (
    .ins_valid (accept),
    .ins_class (dec_class),
    .ser_mode  (ser_mode),
    .dbg_mode  (dbg_mode),
    .req       (req)
  );

  ser_drain_mon #(.CNT_W(CNT_W)) u_drain (
    .inflight_cnt  (inflight_cnt),
    .memq_cnt      (memq_cnt),
    .bufs_empty    (bufs_empty),
    .exec_drained  (exec_drained),
    .fetch_drained (fetch_drained)
  );

  ser_hold_slot #(.TAG_W(TAG_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (slot_load),
    .unload   (slot_unload),
    .load_tag (dec_tag),
    .full     (slot_full),
    .tag      (slot_tag)
  );

  // next-state logic
  always_comb begin
    dec_ready = !slot_full;
    accept    = dec_valid && dec_ready;
    is_ser    = req.need_exec || req.need_fetch;
    slot_load = accept && is_ser;

    // a new request can only arrive with the slot empty, so it never
    // collides with the release of an older one
    if (slot_load && req.need_exec) begin
      exec_pend_nx = 1'b1;
    end else begin
      exec_pend_nx = exec_pend && !exec_drained;
    end

    if (slot_load && req.need_fetch) begin
      fetch_pend_nx = 1'b1;
    end else begin
      fetch_pend_nx = fetch_pend && !fetch_drained;
    end

    slot_unload    = slot_full && !exec_pend_nx && !fetch_pend_nx;
    issue_valid_nx = (accept && !is_ser) || slot_unload;
    issue_tag_en   = issue_valid_nx;
    issue_tag_nx   = slot_unload ? slot_tag : dec_tag;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      exec_pend   <= 1'b0;
      fetch_pend  <= 1'b0;
      issue_valid <= 1'b0;
    end else begin
      exec_pend   <= exec_pend_nx;
      fetch_pend  <= fetch_pend_nx;
      issue_valid <= issue_valid_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      issue_tag <= '0;
    end else if (issue_tag_en) begin
      issue_tag <= issue_tag_nx;
    end
  end

  assign issue_hold = exec_pend;
  assign fetch_hold = fetch_pend;

endmodule

// File: rtl/ser_ctrl_chk.sv
module ser_ctrl_chk #(
  parameter int TAG_W = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic [1:0]       dec_class,
  input logic [TAG_W-1:0] dec_tag,
  input logic             ser_mode,
  input logic             dbg_mode,
  input logic [CNT_W-1:0] inflight_cnt,
  input logic [CNT_W-1:0] memq_cnt,
  input logic             bufs_empty,
  input logic             dec_ready,
  input logic             issue_valid,
  input logic [TAG_W-1:0] issue_tag,
  input logic             issue_hold,
  input logic             fetch_hold
);

  logic take;
  logic plain_cls;
  logic drained_x;
  logic drained_f;

  assign take      = dec_valid && dec_ready;
  assign plain_cls = (dec_class == 2'b00) || (dec_class == 2'b11);
  assign drained_f = (inflight_cnt == '0);
  assign drained_x = drained_f && (memq_cnt == '0) && bufs_empty;

  p_plain_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && plain_cls && !ser_mode && !dbg_mode |=>
      issue_valid && (issue_tag == $past(dec_tag)) && !issue_hold && !fetch_hold);

  p_sync_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && (dec_class == 2'b01) |=> issue_hold && !issue_valid);

  p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hold && !drained_x |=> issue_hold);

  p_hold_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hold && drained_x |=> !issue_hold);

  p_isync_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && (dec_class == 2'b10) |=> fetch_hold);

  p_fetch_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hold && drained_f |=> !fetch_hold);

  p_mode_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && (ser_mode || dbg_mode) |=> fetch_hold && !issue_valid);

  p_split_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hold && fetch_hold && drained_f && !drained_x |=>
      !fetch_hold && issue_hold && !issue_valid);

  p_busy_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_hold || fetch_hold) |-> !dec_ready);

  p_issue_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !issue_hold && !fetch_hold);

endmodule

bind ser_ctrl ser_ctrl_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .dec_valid    (dec_valid),
  .dec_class    (dec_class),
  .dec_tag      (dec_tag),
  .ser_mode     (ser_mode),
  .dbg_mode     (dbg_mode),
  .inflight_cnt (inflight_cnt),
  .memq_cnt     (memq_cnt),
  .bufs_empty   (bufs_empty),
  .dec_ready    (dec_ready),
  .issue_valid  (issue_valid),
  .issue_tag    (issue_tag),
  .issue_hold   (issue_hold),
  .fetch_hold   (fetch_hold)
);

// File: tb/test_ser_ctrl.sv
`timescale 1ns/1ps
module test_ser_ctrl;

  localparam int TAG_W = 8;
  localparam int CNT_W = 4;

  logic             clk;
  logic             rst_n;
  logic             dec_valid;
  logic [1:0]       dec_class;
  logic [TAG_W-1:0] dec_tag;
  logic             ser_mode;
  logic             dbg_mode;
  logic [CNT_W-1:0] inflight_cnt;
  logic [CNT_W-1:0] memq_cnt;
  logic             bufs_empty;
  logic             dec_ready;
  logic             issue_valid;
  logic [TAG_W-1:0] issue_tag;
  logic             issue_hold;
  logic             fetch_hold;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;
  logic [TAG_W-1:0] exp_q[$];

  ser_ctrl #(.TAG_W(TAG_W), .CNT_W(CNT_W)) i_ser_ctrl (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
    .dec_tag(dec_tag), .ser_mode(ser_mode), .dbg_mode(dbg_mode),
    .inflight_cnt(inflight_cnt), .memq_cnt(memq_cnt), .bufs_empty(bufs_empty),
    .dec_ready(dec_ready), .issue_valid(issue_valid), .issue_tag(issue_tag),
    .issue_hold(issue_hold), .fetch_hold(fetch_hold)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // inputs change 2 ns after the rising edge, outputs are read there too
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // driver: present one instruction for a cycle and record what must issue
  task automatic drive(input logic [1:0] cls, input logic [TAG_W-1:0] tag);
    dec_valid = 1;
    dec_class = cls;
    dec_tag   = tag;
    exp_q.push_back(tag);
    tick();
    dec_valid = 0;
  endtask

  task automatic set_busy(input int infl, input int memq, input bit empty);
    inflight_cnt = CNT_W'(infl);
    memq_cnt     = CNT_W'(memq);
    bufs_empty   = empty;
  endtask

  // monitor: every issue is compared with the oldest expected tag
  always @(posedge clk) begin
    #1;
    if (rst_n && issue_valid) begin
      if (exp_q.size() == 0) begin
        check("R9", "unexpected issue tag", issue_tag, 32'hFFFF);
      end else begin
        check("R2", "issued tag order", issue_tag, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dec_valid = 0; dec_class = 0; dec_tag = 0;
    ser_mode = 0; dbg_mode = 0;
    set_busy(0, 0, 1);
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();

    // R1: reset state
    check("R1", "dec_ready", dec_ready, 1);
    check("R1", "issue_valid", issue_valid, 0);
    check("R1", "issue_hold", issue_hold, 0);
    check("R1", "fetch_hold", fetch_hold, 0);

    // R2: plain instruction issues next cycle, no holds
    set_busy(3, 2, 0);
    drive(2'b00, 8'h11);
    check("R2", "issue_valid", issue_valid, 1);
    check("R2", "holds", {issue_hold, fetch_hold}, 0);
    // R10: class 11 acts as plain
    drive(2'b11, 8'h22);
    check("R10", "issue_valid", issue_valid, 1);
    check("R10", "fetch_hold", fetch_hold, 0);
    // back-to-back plain
    drive(2'b00, 8'h31);
    drive(2'b00, 8'h32);
    check("R2", "second issue", issue_valid, 1);
    tick();
    check("R2", "pulse ends", issue_valid, 0);

    // R3/R4/R9: synchronize instruction waits for full drain
    set_busy(2, 1, 0);
    drive(2'b01, 8'h40);
    check("R3", "issue_hold", issue_hold, 1);
    check("R3", "fetch_hold", fetch_hold, 0);
    check("R9", "dec_ready", dec_ready, 0);
    check("R3", "no issue", issue_valid, 0);
    dec_valid = 1; dec_class = 2'b00; dec_tag = 8'h99;  // must be ignored
    tick();
    check("R9", "ignored while busy", issue_valid, 0);
    inflight_cnt = 0;
    tick();
    check("R3", "hold with memq busy", issue_hold, 1);
    check("R9", "ignored while busy", issue_valid, 0);
    memq_cnt = 0;
    tick();
    check("R3", "hold with buffers busy", issue_hold, 1);
    bufs_empty = 1;
    dec_valid = 0;
    tick();
    check("R4", "hold released", issue_hold, 0);
    check("R4", "held instruction issues", issue_valid, 1);
    check("R4", "dec_ready back", dec_ready, 1);
    tick();
    check("R9", "ignored instruction never issues", issue_valid, 0);

    // R3: synchronize on an already drained core still serializes
    drive(2'b01, 8'h45);
    check("R3", "hold when idle", issue_hold, 1);
    check("R3", "no issue when idle", issue_valid, 0);
    tick();
    check("R4", "release after one cycle", issue_valid, 1);
    check("R4", "hold low", issue_hold, 0);

    // R5: instruction-synchronize waits only on in-flight count
    set_busy(1, 2, 0);
    drive(2'b10, 8'h50);
    check("R5", "fetch_hold", fetch_hold, 1);
    check("R5", "issue_hold", issue_hold, 0);
    check("R5", "no issue", issue_valid, 0);
    tick();
    check("R5", "still held", fetch_hold, 1);
    inflight_cnt = 0;
    tick();
    check("R5", "released with memq busy", fetch_hold, 0);
    check("R5", "issues", issue_valid, 1);

    // R6: serialize mode makes a plain instruction fetch-serialize
    set_busy(1, 0, 1);
    ser_mode = 1;
    drive(2'b00, 8'h60);
    check("R6", "fetch_hold", fetch_hold, 1);
    check("R6", "no issue", issue_valid, 0);
    inflight_cnt = 0;
    tick();
    check("R6", "released", fetch_hold, 0);
    check("R6", "issues", issue_valid, 1);
    ser_mode = 0;

    // R7: debug mode does the same
    set_busy(2, 0, 1);
    dbg_mode = 1;
    drive(2'b11, 8'h70);
    check("R7", "fetch_hold", fetch_hold, 1);
    check("R7", "no issue", issue_valid, 0);
    inflight_cnt = 0;
    tick();
    check("R7", "released", fetch_hold, 0);
    check("R7", "issues", issue_valid, 1);
    dbg_mode = 0;

    // R8: both kinds at once, released independently
    set_busy(2, 1, 1);
    ser_mode = 1;
    drive(2'b01, 8'h80);
    check("R8", "both holds", {issue_hold, fetch_hold}, 2'b11);
    inflight_cnt = 0;
    tick();
    check("R8", "fetch released first", fetch_hold, 0);
    check("R8", "issue hold remains", issue_hold, 1);
    check("R8", "no issue yet", issue_valid, 0);
    memq_cnt = 0;
    tick();
    check("R8", "issue hold released", issue_hold, 0);
    check("R8", "issues", issue_valid, 1);
    ser_mode = 0;

    // R11 is covered throughout by the checker; drain the scoreboard
    repeat (3) tick();
    check("R2", "all expected issued", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule